// File: doc/BRIEF.md
# Masked Content-Addressable Word Store

The block keeps a small table of words, each with a live flag. Words are written by index. A search compares every live word at the same time against a stored argument. Only the bit positions that a stored key mask enables take part in that comparison. The result is one hit bit per word, and it is captured in a match vector that holds its value until the next search.

After each search, a drain sequencer walks the captured hits from the lowest index upward. It presents one matching word, with its index, on each cycle. It raises a done flag once the walk has finished.

Software-side logic loads the argument and key through their own strobes, then pulses the search strobe, then collects the streamed results.

Top module: `mcam_top`

## Requirements
- R1: After synchronous reset, `match_vec`, `rd_valid` and `rd_done` are all 0, and every word is not live.
- R2: A cycle with `wr_en` high stores `wr_word` into word `wr_idx` and sets that word's live flag to `wr_live`. Writing with `wr_live`=0 removes a word from all later searches. Rewriting it with `wr_live`=1 restores it.
- R3: With the key all ones, word i hits only if all of its bits equal the argument.
- R4: Key bit j = 0 removes position j from the comparison. Word i hits when, for every j, the stored bit equals the argument bit or key bit j is 0. An all-zero key therefore hits every live word.
- R5: A word that is not live never hits, whatever the key holds.
- R6: A search strobe sampled at a clock edge compares all words at once. The result appears on `match_vec` after that same edge, with bit i for word i.
- R7: Starting at the first edge after the search edge, one hit word is output per cycle in ascending index order. Each output has `rd_valid`=1, `rd_idx` set to the index and `rd_word` set to the stored content.
- R8: `rd_done` rises one cycle after the last hit word has been output. With no hits, it rises at the first edge after the search edge. It stays high until the next search edge clears it, and it is never high together with `rd_valid`.
- R9: Writes that happen during a walk leave `match_vec` and the set of walked indices unchanged until the next search.
- R10: `arg_ld` and `key_ld` load `arg_in` and `key_in` at a clock edge. A search uses the values that were loaded at earlier edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Word write strobe |
| wr_idx | input | IDX_W | Word index to write |
| wr_word | input | WIDTH | Content to store |
| wr_live | input | 1 | Live flag stored with the word |
| arg_ld | input | 1 | Argument load strobe |
| arg_in | input | WIDTH | Argument value |
| key_ld | input | 1 | Key mask load strobe |
| key_in | input | WIDTH | Key mask value, 1 = compare this bit |
| srch | input | 1 | Search strobe |
| match_vec | output | WORDS | Captured hit bits of the last search |
| rd_valid | output | 1 | A hit word is presented this cycle |
| rd_idx | output | IDX_W | Index of presented word |
| rd_word | output | WIDTH | Content of presented word |
| rd_done | output | 1 | Walk of last search finished |

## Verification
The hardest situation to reach from the ports is a write that lands while the drain walk is still running. It must be shown that neither the captured hit vector nor the walked index set follows that write.

The stimulus therefore issues a search with several hits. On the first walk cycle it rewrites the lowest hit word so that it no longer matches, and it also turns a non-matching word into a matching one. It then checks the match vector and the streamed sequence against the values predicted at the moment of the search.

Invalidated words are also searched with an all-zero key, which isolates the live-flag rule.

// File: rtl/mcam_pkg.sv
package mcam_pkg;

    // Widest word and deepest table the helper functions accept.
    localparam int MAX_W = 64;

    typedef enum logic [1:0] {
        DR_IDLE,
        DR_WALK,
        DR_DONE
    } drain_state_e;

    // Masked equality: every position either agrees or is excluded by the key.
    function automatic logic masked_agree(input logic [MAX_W-1:0] stored,
                                          input logic [MAX_W-1:0] arg,
                                          input logic [MAX_W-1:0] key);
        return &(~(stored ^ arg) | ~key);
    endfunction

    // Index of the lowest set bit, 0 when none is set.
    function automatic int unsigned lowest_set(input logic [MAX_W-1:0] v);
        int unsigned r;
        r = 0;
        for (int b = MAX_W - 1; b >= 0; b--) begin
            if (v[b]) r = b;
        end
        return r;
    endfunction

endpackage

// File: rtl/mcam_store.sv
module mcam_store
    import mcam_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int WIDTH = 16,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_word,
    input  logic             wr_live,
    input  logic [WIDTH-1:0] arg_q,
    input  logic [WIDTH-1:0] key_q,
    input  logic [IDX_W-1:0] pick_idx,
    output logic [WORDS-1:0] hit,
    output logic [WIDTH-1:0] pick_word
);

    logic [WORDS-1:0][WIDTH-1:0] cells;
    logic [WORDS-1:0]            live;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [WIDTH-1:0] cell_q;
        logic             live_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= '0;
                live_q <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                cell_q <= wr_word;
                live_q <= wr_live;
            end
        end

        assign cells[i] = cell_q;
        assign live[i]  = live_q;
        assign hit[i]   = live_q & masked_agree(MAX_W'(cell_q), MAX_W'(arg_q), MAX_W'(key_q));
    end

    assign pick_word = cells[pick_idx];

    // R5: a word that is not live never reports a hit
    a_r5_dead_no_hit: assert property (@(posedge clk) disable iff (rst)
        (hit & ~live) == '0);

endmodule

// File: rtl/mcam_match_reg.sv
module mcam_match_reg #(
    parameter int WORDS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             srch,
    input  logic [WORDS-1:0] hit,
    output logic [WORDS-1:0] match_q
);

    always_ff @(posedge clk) begin
        if (rst)       match_q <= '0;
        else if (srch) match_q <= hit;
    end

    // R9: captured vector only moves at a search edge
    a_r9_hold_match: assert property (@(posedge clk) disable iff (rst)
        !srch |=> $stable(match_q));

endmodule

// File: rtl/mcam_drain.sv
module mcam_drain
    import mcam_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int WIDTH = 16,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             srch,
    input  logic [WORDS-1:0] hit,
    input  logic [WIDTH-1:0] pick_word,
    output logic [IDX_W-1:0] pick_idx,
    output logic             rd_valid,
    output logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_word,
    output logic             rd_done
);

    drain_state_e     state;
    logic [WORDS-1:0] pend;

    assign pick_idx = IDX_W'(lowest_set(MAX_W'(pend)));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= DR_IDLE;
            pend     <= '0;
            rd_valid <= 1'b0;
            rd_idx   <= '0;
            rd_word  <= '0;
            rd_done  <= 1'b0;
        end else if (srch) begin
            state    <= DR_WALK;
            pend     <= hit;
            rd_valid <= 1'b0;
            rd_done  <= 1'b0;
        end else begin
            case (state)
                DR_WALK: begin
                    if (|pend) begin
                        rd_valid       <= 1'b1;
                        rd_idx         <= pick_idx;
                        rd_word        <= pick_word;
                        pend[pick_idx] <= 1'b0;
                    end else begin
                        rd_valid <= 1'b0;
                        rd_done  <= 1'b1;
                        state    <= DR_DONE;
                    end
                end
                default: rd_valid <= 1'b0;
            endcase
        end
    end

    // R7: consecutive outputs climb in index
    a_r7_ascending: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(rd_valid)) |-> (rd_idx > $past(rd_idx)));

    // R8: done and a data beat never coincide
    a_r8_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && rd_done));

    // R8: a search edge clears done
    a_r8_srch_clears: assert property (@(posedge clk) disable iff (rst)
        srch |=> !rd_done && !rd_valid);

    // R8: done holds until the next search
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (rd_done && !srch) |=> rd_done);

endmodule

// File: rtl/mcam_top.sv
module mcam_top
    import mcam_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int WIDTH = 16,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_word,
    input  logic             wr_live,
    input  logic             arg_ld,
    input  logic [WIDTH-1:0] arg_in,
    input  logic             key_ld,
    input  logic [WIDTH-1:0] key_in,
    input  logic             srch,
    output logic [WORDS-1:0] match_vec,
    output logic             rd_valid,
    output logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_word,
    output logic             rd_done
);

    logic [WIDTH-1:0] arg_q;
    logic [WIDTH-1:0] key_q;
    logic [WORDS-1:0] hit;
    logic [IDX_W-1:0] pick_idx;
    logic [WIDTH-1:0] pick_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            arg_q <= '0;
            key_q <= '0;
        end else begin
            if (arg_ld) arg_q <= arg_in;
            if (key_ld) key_q <= key_in;
        end
    end

    mcam_store #(.WORDS(WORDS), .WIDTH(WIDTH)) store_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word), .wr_live(wr_live),
        .arg_q(arg_q), .key_q(key_q),
        .pick_idx(pick_idx), .hit(hit), .pick_word(pick_word)
    );

    mcam_match_reg #(.WORDS(WORDS)) match_i (
        .clk(clk), .rst(rst), .srch(srch), .hit(hit), .match_q(match_vec)
    );

    mcam_drain #(.WORDS(WORDS), .WIDTH(WIDTH)) drain_i (
        .clk(clk), .rst(rst), .srch(srch), .hit(hit), .pick_word(pick_word),
        .pick_idx(pick_idx), .rd_valid(rd_valid), .rd_idx(rd_idx),
        .rd_word(rd_word), .rd_done(rd_done)
    );

    // R7: every streamed index belongs to the captured hit set
    a_r7_in_match: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> match_vec[rd_idx]);

endmodule

// File: tb/mcam_top_tb_top.sv
module mcam_top_tb_top;

    localparam int N  = 8;
    localparam int W  = 16;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [W-1:0]  wr_word = '0;
    logic          wr_live = 1'b0;
    logic          arg_ld = 1'b0;
    logic [W-1:0]  arg_in = '0;
    logic          key_ld = 1'b0;
    logic [W-1:0]  key_in = '0;
    logic          srch = 1'b0;
    logic [N-1:0]  match_vec;
    logic          rd_valid;
    logic [IW-1:0] rd_idx;
    logic [W-1:0]  rd_word;
    logic          rd_done;

    always #4 clk = ~clk;

    mcam_top #(.WORDS(N), .WIDTH(W)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
        .wr_live(wr_live), .arg_ld(arg_ld), .arg_in(arg_in), .key_ld(key_ld),
        .key_in(key_in), .srch(srch), .match_vec(match_vec), .rd_valid(rd_valid),
        .rd_idx(rd_idx), .rd_word(rd_word), .rd_done(rd_done)
    );

    typedef struct packed {
        logic [IW-1:0] idx;
        logic [W-1:0]  word;
    } beat_t;

    beat_t        exp_q[$];
    logic [W-1:0] m_word [N];
    logic         m_live [N];
    logic [W-1:0] m_arg = '0;
    logic [W-1:0] m_key = '0;
    int           n_chk = 0;
    int           n_fail = 0;
    string        cur_tag = "R7";

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every streamed beat
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk({cur_tag, " unexpected beat idx"}, 64'(rd_idx), 64'hFFFF);
            end else begin
                beat_t e;
                e = exp_q.pop_front();
                chk({cur_tag, " R7 idx"}, 64'(rd_idx), 64'(e.idx));
                chk({cur_tag, " R7 word"}, 64'(rd_word), 64'(e.word));
            end
        end
    end

    task automatic write_word(input int i, input logic [W-1:0] v, input logic live);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(i); wr_word = v; wr_live = live;
        @(negedge clk);
        wr_en = 1'b0;
        m_word[i] = v; m_live[i] = live;
    endtask

    task automatic load(input logic [W-1:0] a, input logic [W-1:0] k);
        @(negedge clk);
        arg_ld = 1'b1; arg_in = a; key_ld = 1'b1; key_in = k;
        @(negedge clk);
        arg_ld = 1'b0; key_ld = 1'b0;
        m_arg = a; m_key = k;
    endtask

    // Driver: predicts hits, fills the scoreboard, runs the search
    task automatic run_search(input string tag, input bit inj,
                              input int inj_a, input logic [W-1:0] inj_wa,
                              input int inj_b, input logic [W-1:0] inj_wb);
        logic [N-1:0] exp_v;
        int k;
        exp_v = '0;
        for (int i = 0; i < N; i++) begin
            exp_v[i] = m_live[i] && (((m_word[i] ^ m_arg) & m_key) == '0);
            if (exp_v[i]) begin
                beat_t b;
                b.idx = IW'(i); b.word = m_word[i];
                exp_q.push_back(b);
            end
        end
        k = $countones(exp_v);
        cur_tag = tag;
        @(negedge clk);
        srch = 1'b1;
        @(negedge clk);
        srch = 1'b0;
        chk({tag, " R6 match_vec"}, 64'(match_vec), 64'(exp_v));
        for (int c = 1; c <= k + 1; c++) begin
            if (c == 1 && inj) begin
                wr_en = 1'b1; wr_idx = IW'(inj_a); wr_word = inj_wa; wr_live = 1'b1;
                @(negedge clk);
                wr_idx = IW'(inj_b); wr_word = inj_wb;
                m_word[inj_a] = inj_wa; m_live[inj_a] = 1'b1;
            end else begin
                @(negedge clk);
            end
            if (c == 2 && inj) begin
                wr_en = 1'b0;
                m_word[inj_b] = inj_wb; m_live[inj_b] = 1'b1;
            end
            chk({tag, " R8 done timing"}, 64'(rd_done), (c == k + 1) ? 64'd1 : 64'd0);
        end
        if (inj && k < 2) begin
            @(negedge clk);
            wr_en = 1'b0;
            m_word[inj_b] = inj_wb; m_live[inj_b] = 1'b1;
        end
        @(negedge clk);
        chk({tag, " R8 done sticky"}, 64'(rd_done), 64'd1);
        chk({tag, " R9 match held"}, 64'(match_vec), 64'(exp_v));
        chk({tag, " R7 scoreboard drained"}, 64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin m_word[i] = '0; m_live[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 match_vec", 64'(match_vec), 64'd0);
        chk("R1 rd_valid", 64'(rd_valid), 64'd0);
        chk("R1 rd_done", 64'(rd_done), 64'd0);
        // R1: nothing is live, so an all-zero key search hits nothing
        load(16'h0000, 16'h0000);
        run_search("R1_R5 empty table", 1'b0, 0, '0, 0, '0);

        write_word(0, 16'hA5C3, 1'b1);
        write_word(1, 16'hA5FF, 1'b1);
        write_word(2, 16'h1234, 1'b1);
        write_word(3, 16'hA5C3, 1'b1);
        write_word(4, 16'h0000, 1'b1);
        write_word(5, 16'hFFFF, 1'b1);
        write_word(6, 16'hA500, 1'b1);
        write_word(7, 16'hA5C3, 1'b1);
        write_word(7, 16'hA5C3, 1'b0);   // R2: invalidate word 7

        load(16'hA5C3, 16'hFFFF);
        run_search("R3_R5 full key", 1'b0, 0, '0, 0, '0);
        load(16'hA577, 16'hFF00);
        run_search("R4 upper byte key", 1'b0, 0, '0, 0, '0);
        load(16'h5A5A, 16'h0000);
        run_search("R4_R5 zero key", 1'b0, 0, '0, 0, '0);
        load(16'h1235, 16'hFFFE);
        run_search("R4 single bit excluded", 1'b0, 0, '0, 0, '0);
        load(16'h9999, 16'hFFFF);
        run_search("R8 no hit", 1'b0, 0, '0, 0, '0);

        // R10: same-edge load and search uses the older argument
        @(negedge clk);
        arg_ld = 1'b1; arg_in = 16'h1234; srch = 1'b1;
        @(negedge clk);
        arg_ld = 1'b0; srch = 1'b0;
        chk("R10 old arg at same edge", 64'(match_vec), 64'd0);
        m_arg = 16'h1234;
        while (!rd_done) @(negedge clk);
        run_search("R10 new arg later", 1'b0, 0, '0, 0, '0);

        // R9: during the walk rewrite word 0 to miss and word 4 to hit
        load(16'hA5C3, 16'hFFFF);
        run_search("R9 write during walk", 1'b1, 0, 16'h0F0F, 4, 16'hA5C3);
        run_search("R9 next search sees writes", 1'b0, 0, '0, 0, '0);

        // R2: revive word 7
        write_word(7, 16'hA5C3, 1'b1);
        run_search("R2 revived word", 1'b0, 0, '0, 0, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R8 actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule